// File: doc/BRIEF.md
# Scalar Double-Precision Flag Comparator

This block compares two IEEE-754 double-precision numbers and turns the outcome into condition flags for a processor flags register. Each operand arrives on a 128-bit bus. Only the low 64 bits hold the value that is compared. The result falls into one of four classes: unordered, greater, less or equal. Each class maps to a fixed pattern on the zero, parity and carry flags. The overflow, auxiliary and sign flags are cleared whenever the flags are written.

A one-cycle `valid_i` pulse starts a compare. The flags register and the `done_o` strobe update on the next rising clock edge. A signaling NaN on either operand raises an invalid-operation pulse. If the invalid-operation exception is unmasked, the flag write is withheld and an exception pulse is raised instead. A quiet NaN gives the unordered result with no invalid indication. Ordering follows the sign-magnitude value of the encodings: denormals are compared by value, and the two zeros are equal.

Top module: `dp_flag_cmp`

## Requirements
- R1: Bits 127:64 of both operand inputs have no effect on any output; only bits 63:0 are compared.
- R2: If either operand is a NaN (exponent bits 62:52 all ones, fraction bits 51:0 nonzero) and the flags are written, then zf_o=1, pf_o=1 and cf_o=1.
- R3: If operand A is greater than operand B, the written flags are zf_o=0, pf_o=0, cf_o=0.
- R4: If operand A is less than operand B, the written flags are zf_o=0, pf_o=0, cf_o=1.
- R5: If the operands are equal, the written flags are zf_o=1, pf_o=0, cf_o=0. Positive zero and negative zero are equal.
- R6: Every flag write sets of_o, af_o and sf_o to 0.
- R7: A signaling NaN operand (NaN with fraction bit 51 = 0) drives inv_o high for one cycle in the cycle after valid_i. A quiet NaN (fraction bit 51 = 1) leaves inv_o low.
- R8: With a signaling NaN and inv_mask_i=0 (unmasked), all six flags keep their previous values and xcpt_o pulses for one cycle. With inv_mask_i=1, the flags are written as unordered and xcpt_o stays low.
- R9: Ordering uses sign-magnitude order of the 64-bit encodings with no flush-to-zero, so denormals and infinities compare by value.
- R10: done_o is high for exactly the one cycle after each valid_i pulse. The flags change only on that edge.
- R11: While rst_ni is low, all six flags, done_o, inv_o and xcpt_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | One-cycle compare start |
| opa_i | input | 128 | Operand A; value in bits 63:0 |
| opb_i | input | 128 | Operand B; value in bits 63:0 |
| inv_mask_i | input | 1 | 1 = invalid-operation exception masked |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Parity flag |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| af_o | output | 1 | Auxiliary flag |
| sf_o | output | 1 | Sign flag |
| done_o | output | 1 | Compare completed strobe |
| inv_o | output | 1 | Invalid-operation indication (signaling NaN seen) |
| xcpt_o | output | 1 | Unmasked exception; flag write withheld |

## Verification
All state sits in one register stage, so a wrong classification appears on the flag outputs in the cycle after `valid_i`. It shows as a pattern that should not occur, such as parity set without zero and carry, or as the wrong one of the four patterns. A faulty suppression path shows up as flags that change while `xcpt_o` is high, or as flags that stay unchanged on a masked signaling NaN. A wrong strobe or leftover state from a previous compare is visible as `done_o` high without a preceding `valid_i`, or as flags that move while no compare is in progress.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [1:0] {
    CLS_GT = 2'd0,
    CLS_LT = 2'd1,
    CLS_EQ = 2'd2,
    CLS_UN = 2'd3
  } cmp_cls_e;

  typedef struct packed {
    logic zf;
    logic pf;
    logic cf;
  } zpc_t;

  typedef struct packed {
    logic of;
    logic af;
    logic sf;
    logic zf;
    logic pf;
    logic cf;
  } flags_t;

  function automatic zpc_t cls_to_zpc(cmp_cls_e cls);
    zpc_t r;
    case (cls)
      CLS_UN:  r = '{zf: 1'b1, pf: 1'b1, cf: 1'b1};
      CLS_LT:  r = '{zf: 1'b0, pf: 1'b0, cf: 1'b1};
      CLS_EQ:  r = '{zf: 1'b1, pf: 1'b0, cf: 1'b0};
      default: r = '{zf: 1'b0, pf: 1'b0, cf: 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dpc_classify.sv
module dpc_classify #(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  localparam int unsigned FP_W  = 1 + EXP_W + FRAC_W
) (
  input  logic [FP_W-1:0]  val_i,
  output logic             sign_o,
  output logic [FP_W-2:0]  mag_o,
  output logic             nan_o,
  output logic             snan_o,
  output logic             zero_o
);

  logic [EXP_W-1:0]  exp_w;
  logic [FRAC_W-1:0] frac_w;
  logic              exp_max;
  logic              frac_nz;

  assign sign_o  = val_i[FP_W-1];
  assign mag_o   = val_i[FP_W-2:0];
  assign exp_w   = val_i[FP_W-2:FRAC_W];
  assign frac_w  = val_i[FRAC_W-1:0];
  assign exp_max = &exp_w;
  assign frac_nz = |frac_w;

  assign nan_o   = exp_max && frac_nz;
  // quiet bit is fraction MSB
  assign snan_o  = nan_o && !frac_w[FRAC_W-1];
  assign zero_o  = ~|mag_o;

endmodule

// File: rtl/dpc_order.sv
module dpc_order
  import dpc_pkg::*;
#(
  parameter int unsigned MAG_W = 63
) (
  input  logic             sign_a_i,
  input  logic [MAG_W-1:0] mag_a_i,
  input  logic             nan_a_i,
  input  logic             zero_a_i,
  input  logic             sign_b_i,
  input  logic [MAG_W-1:0] mag_b_i,
  input  logic             nan_b_i,
  input  logic             zero_b_i,
  output cmp_cls_e         cls_o
);

  logic mag_gt, mag_eq;

  assign mag_gt = mag_a_i > mag_b_i;
  assign mag_eq = mag_a_i == mag_b_i;

  always_comb begin
    if (nan_a_i || nan_b_i) begin
      cls_o = CLS_UN;
    end else if (zero_a_i && zero_b_i) begin
      cls_o = CLS_EQ;                       // +0 == -0
    end else if (sign_a_i != sign_b_i) begin
      cls_o = sign_a_i ? CLS_LT : CLS_GT;
    end else if (mag_eq) begin
      cls_o = CLS_EQ;
    end else if (mag_gt ^ sign_a_i) begin  // negative side reverses
      cls_o = CLS_GT;
    end else begin
      cls_o = CLS_LT;
    end
  end

endmodule

// File: rtl/dpc_flag_reg.sv
module dpc_flag_reg
  import dpc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   valid_i,
  input  zpc_t   zpc_i,
  input  logic   snan_i,
  input  logic   inv_mask_i,
  output flags_t flags_o,
  output logic   done_o,
  output logic   inv_o,
  output logic   xcpt_o
);

  flags_t flags_q;
  logic   done_q, inv_q, xcpt_q;
  logic   suppress;
  logic   wr_en;

  assign suppress = snan_i && !inv_mask_i;
  assign wr_en    = valid_i && !suppress;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      done_q  <= 1'b0;
      inv_q   <= 1'b0;
      xcpt_q  <= 1'b0;
    end else begin
      done_q <= valid_i;
      inv_q  <= valid_i && snan_i;
      xcpt_q <= valid_i && suppress;
      if (wr_en) begin
        flags_q <= '{of: 1'b0, af: 1'b0, sf: 1'b0,
                     zf: zpc_i.zf, pf: zpc_i.pf, cf: zpc_i.cf};
      end
    end
  end

  assign flags_o = flags_q;
  assign done_o  = done_q;
  assign inv_o   = inv_q;
  assign xcpt_o  = xcpt_q;

endmodule

// File: rtl/dp_flag_cmp.sv
module dp_flag_cmp
  import dpc_pkg::*;
#(
  parameter int unsigned BUS_W  = 128,
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  localparam int unsigned FP_W  = 1 + EXP_W + FRAC_W,
  localparam int unsigned MAG_W = FP_W - 1,
  localparam int unsigned N_OP  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [BUS_W-1:0] opa_i,
  input  logic [BUS_W-1:0] opb_i,
  input  logic             inv_mask_i,
  output logic             zf_o,
  output logic             pf_o,
  output logic             cf_o,
  output logic             of_o,
  output logic             af_o,
  output logic             sf_o,
  output logic             done_o,
  output logic             inv_o,
  output logic             xcpt_o
);

  logic [FP_W-1:0]  op_val  [N_OP];
  logic             op_sign [N_OP];
  logic [MAG_W-1:0] op_mag  [N_OP];
  logic             op_nan  [N_OP];
  logic             op_snan [N_OP];
  logic             op_zero [N_OP];

  logic     unused_hi;
  cmp_cls_e cls;
  zpc_t     zpc;
  flags_t   flags;
  logic     snan_any;

  assign op_val[0] = opa_i[FP_W-1:0];
  assign op_val[1] = opb_i[FP_W-1:0];
  assign unused_hi = ^{opa_i[BUS_W-1:FP_W], opb_i[BUS_W-1:FP_W]};

  for (genvar g = 0; g < N_OP; g++) begin : g_op
    dpc_classify #(
      .EXP_W  (EXP_W),
      .FRAC_W (FRAC_W)
    ) u_cls (
      .val_i  (op_val[g]),
      .sign_o (op_sign[g]),
      .mag_o  (op_mag[g]),
      .nan_o  (op_nan[g]),
      .snan_o (op_snan[g]),
      .zero_o (op_zero[g])
    );
  end

  dpc_order #(
    .MAG_W (MAG_W)
  ) u_order (
    .sign_a_i (op_sign[0]),
    .mag_a_i  (op_mag[0]),
    .nan_a_i  (op_nan[0]),
    .zero_a_i (op_zero[0]),
    .sign_b_i (op_sign[1]),
    .mag_b_i  (op_mag[1]),
    .nan_b_i  (op_nan[1]),
    .zero_b_i (op_zero[1]),
    .cls_o    (cls)
  );

  assign zpc      = cls_to_zpc(cls);
  assign snan_any = op_snan[0] || op_snan[1];

  dpc_flag_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .zpc_i      (zpc),
    .snan_i     (snan_any),
    .inv_mask_i (inv_mask_i),
    .flags_o    (flags),
    .done_o     (done_o),
    .inv_o      (inv_o),
    .xcpt_o     (xcpt_o)
  );

  assign zf_o = flags.zf;
  assign pf_o = flags.pf;
  assign cf_o = flags.cf;
  assign of_o = flags.of;
  assign af_o = flags.af;
  assign sf_o = flags.sf;

endmodule

// File: rtl/dpc_chk.sv
module dpc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic inv_mask_i,
  input logic zf_o,
  input logic pf_o,
  input logic cf_o,
  input logic of_o,
  input logic af_o,
  input logic sf_o,
  input logic done_o,
  input logic inv_o,
  input logic xcpt_o
);

  // R2
  parity_implies_un_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_o |-> (zf_o && cf_o));

  // R3
  legal_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !xcpt_o) |-> ({zf_o, pf_o, cf_o} inside {3'b111, 3'b000, 3'b001, 3'b100}));

  // R6
  clear_ofs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !xcpt_o) |-> !(of_o || af_o || sf_o));

  // R7
  inv_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_o |-> done_o);

  // R8
  suppress_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xcpt_o |-> ($stable({zf_o, pf_o, cf_o, of_o, af_o, sf_o}) && inv_o));

  // R8
  xcpt_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xcpt_o |-> $past(!inv_mask_i));

  // R10
  done_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);

  // R10
  done_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);

  // R10
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({zf_o, pf_o, cf_o, of_o, af_o, sf_o}));

endmodule

bind dp_flag_cmp dpc_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .inv_mask_i (inv_mask_i),
  .zf_o       (zf_o),
  .pf_o       (pf_o),
  .cf_o       (cf_o),
  .of_o       (of_o),
  .af_o       (af_o),
  .sf_o       (sf_o),
  .done_o     (done_o),
  .inv_o      (inv_o),
  .xcpt_o     (xcpt_o)
);

// File: tb/sim_dp_flag_cmp.sv
module sim_dp_flag_cmp;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] opa_i = '0;
  logic [127:0] opb_i = '0;
  logic         inv_mask_i = 1'b1;
  logic zf_o, pf_o, cf_o, of_o, af_o, sf_o, done_o, inv_o, xcpt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  dp_flag_cmp u0 (
    .clk_i, .rst_ni, .valid_i, .opa_i, .opb_i, .inv_mask_i,
    .zf_o, .pf_o, .cf_o, .of_o, .af_o, .sf_o, .done_o, .inv_o, .xcpt_o
  );

  localparam logic [63:0] P1   = 64'h3FF0000000000000;
  localparam logic [63:0] P2   = 64'h4000000000000000;
  localparam logic [63:0] N1   = 64'hBFF0000000000000;
  localparam logic [63:0] N2   = 64'hC000000000000000;
  localparam logic [63:0] PZ   = 64'h0000000000000000;
  localparam logic [63:0] NZ   = 64'h8000000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] NINF = 64'hFFF0000000000000;
  localparam logic [63:0] QNAN = 64'h7FF8000000000000;
  localparam logic [63:0] SNAN = 64'h7FF0000000000001;
  localparam logic [63:0] DEN1 = 64'h0000000000000001;
  localparam logic [63:0] DEN2 = 64'h0000000000000002;
  localparam logic [63:0] NDEN = 64'h8000000000000001;

  localparam int NV = 16;
  // zf,pf,cf expected
  localparam logic [63:0] VA [NV] = '{P1, P2, P1, N1, N2, PZ, N1, PINF,
                                      NINF, QNAN, P1, DEN1, NDEN, DEN1, PINF, N1};
  localparam logic [63:0] VB [NV] = '{P2, P1, P1, N2, N1, NZ, PZ, P2,
                                      N2, P1, QNAN, DEN2, PZ, PZ, PINF, P1};
  localparam logic [2:0]  VE [NV] = '{3'b001, 3'b000, 3'b100, 3'b000, 3'b001, 3'b100, 3'b001, 3'b000,
                                      3'b001, 3'b111, 3'b111, 3'b001, 3'b001, 3'b000, 3'b100, 3'b001};

  function automatic logic [5:0] flags();
    return {of_o, af_o, sf_o, zf_o, pf_o, cf_o};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cmp(input logic [127:0] a, input logic [127:0] b, input logic m);
    @(negedge clk_i);
    opa_i = a; opb_i = b; inv_mask_i = m; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      finish_run();
    end
  end

  initial begin
    logic [5:0] prev;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11 reset", {flags(), done_o, inv_o, xcpt_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table; upper bits carry garbage (R1)
    for (int i = 0; i < NV; i++) begin
      cmp({~VA[i], VA[i]}, {VA[i] ^ 64'h5A5A5A5A5A5A5A5A, VB[i]}, 1'b1);
      chk($sformatf("R2-5/R9 vec%0d", i), {2'b00, flags()}, {5'b00000, VE[i]});
      chk($sformatf("R6/R7/R10 vec%0d", i), {5'b0, done_o, inv_o, xcpt_o}, 8'b100);
    end

    // R1: upper halves differ wildly, low halves equal
    cmp({64'hFFFFFFFFFFFFFFFF, P1}, {QNAN, P1}, 1'b1);
    chk("R1 upper ignored", {2'b00, flags()}, 8'h04);

    // R10: idle cycles do not move flags or done
    opa_i = {64'h0, P2}; opb_i = {64'h0, P1};
    @(negedge clk_i); @(negedge clk_i);
    chk("R10 idle", {1'b0, flags(), done_o}, {1'b0, 6'b000100, 1'b0});

    // R7/R8 masked SNaN: written unordered, inv set, no xcpt
    cmp({64'h0, SNAN}, {64'h0, P1}, 1'b1);
    chk("R8 masked flags", {2'b00, flags()}, 8'h07);
    chk("R7 masked inv", {5'b0, done_o, inv_o, xcpt_o}, 8'b110);
    @(negedge clk_i);
    chk("R7 inv one cycle", {5'b0, done_o, inv_o, xcpt_o}, 8'b000);

    // set LT then unmasked SNaN: flags hold
    cmp({64'h0, P1}, {64'h0, P2}, 1'b0);
    chk("R4 before suppress", {2'b00, flags()}, 8'h01);
    prev = flags();
    cmp({64'h0, P1}, {64'h0, SNAN}, 1'b0);
    chk("R8 unmasked hold", {2'b00, flags()}, {2'b00, prev});
    chk("R8 unmasked xcpt", {5'b0, done_o, inv_o, xcpt_o}, 8'b111);
    @(negedge clk_i);
    chk("R8 xcpt one cycle", {5'b0, done_o, inv_o, xcpt_o}, 8'b000);

    // R7: quiet NaN unmasked raises nothing, flags unordered
    cmp({64'h0, QNAN}, {64'h0, N1}, 1'b0);
    chk("R7 qnan flags", {2'b00, flags()}, 8'h07);
    chk("R7 qnan no inv", {5'b0, done_o, inv_o, xcpt_o}, 8'b100);

    // R9: negative denormal vs negative zero is less; -den vs -den2 greater
    cmp({64'h0, NDEN}, {64'h0, NZ}, 1'b1);
    chk("R9 negden<-0", {2'b00, flags()}, 8'h01);
    cmp({64'h0, NDEN}, {64'h0, 64'h8000000000000002}, 1'b1);
    chk("R9 -den1>-den2", {2'b00, flags()}, 8'h00);
    // R5: -0 vs +0
    cmp({64'h0, NZ}, {64'h0, PZ}, 1'b1);
    chk("R5 -0==+0", {2'b00, flags()}, 8'h04);

    // R11: reset with nonzero flags clears all
    cmp({64'h0, QNAN}, {64'h0, PZ}, 1'b1);
    rst_ni = 1'b0;
    #1;
    chk("R11 async clear", {flags(), done_o, inv_o, xcpt_o}, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    finished = 1'b1;
    finish_run();
  end

endmodule